// File: doc/BRIEF.md
# Multi-Queue Threshold Interrupt Generator

This block holds one 32-bit threshold control word made of four 8-bit fields. It compares those fields with live counts from three queues and raises a level-sensitive status flag for each queue while the programmed condition holds. The three queues are an in-band-interrupt (IBI) status queue, a response queue and a command queue. The IBI status queue and the response queue report how many entries they hold. The command queue reports how many of its slots are free.

Software writes the whole word through a simple write strobe and can read it back at any time. The field that sets the IBI data segment size in 4-byte words is only stored and passed out to a downstream segmenter. It has no effect on the flags.

Field layout, which software and the segmenter decode: bits 31:24 hold the IBI status threshold, bits 23:16 the segment size, bits 15:8 the response threshold and bits 7:0 the command free-space threshold. Each flag is registered.

Top module: `qthresh_irq`

## Requirements
- R1: After reset, `rd_data` reads 0x01000100: IBI status field 1, segment field 0, response field 1, command field 0. All three flags are low.
- R2: When `wr_en` is high at a rising edge, the word stores `wr_data`. From the next cycle, `rd_data` returns it exactly as written, including out-of-range field values.
- R3: The IBI flag (`ibi_irq`) is high when `ibi_count` ≥ field+1, where the field is bits 31:24 and takes values 0 to 7.
- R4: An IBI status field above 7 is compared as 7, so the flag then needs a full queue of 8 entries.
- R5: The response flag (`resp_irq`) is high when `resp_count` ≥ field+1, where the field is bits 15:8 and takes values 0 to 3.
- R6: A response field above 3 is compared as 3, so the flag then needs 4 entries.
- R7: With a command field N (bits 7:0) from 1 to 7, the command flag (`cmd_irq`) is high when `cmd_free` ≥ N.
- R8: With a command field of 0, `cmd_irq` is high only when `cmd_free` equals 8, meaning the command queue is entirely empty.
- R9: A command field above 7 is compared as 7.
- R10: Each flag is registered. It takes its new value at the first rising edge after a count or threshold changes, and it falls at that same edge once the condition no longer holds.
- R11: `seg_size` always equals bits 23:16 of the stored word. Its value never affects any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the threshold word |
| wr_data | input | 32 | Threshold word to store |
| rd_data | output | 32 | Stored threshold word |
| ibi_count | input | 4 | Entries in the IBI status queue (0 to 8) |
| resp_count | input | 3 | Entries in the response queue (0 to 4) |
| cmd_free | input | 4 | Free slots in the command queue (0 to 8) |
| ibi_irq | output | 1 | IBI status threshold flag |
| resp_irq | output | 1 | Response threshold flag |
| cmd_irq | output | 1 | Command free-space flag |
| seg_size | output | 8 | IBI data segment size in 4-byte words |

## Verification
The bench sweeps every count against every legal field value. This catches an off-by-one in the N+1 encoding, which would fire a flag one entry early or one entry late.

Out-of-range fields such as 9 and 255 are written for each queue. A design without clamping would never raise the flag, because the comparison could not be met.

A command field of 0 is tested with 7 and 8 free slots. A design that treats 0 as "zero free slots" would fire at every count.

The bench also checks the exact edge at which a flag rises and falls, and changes the segment field while the counts stay fixed. Extra pipelining, or a segment field leaking into the compare, would show up as a changed flag.

// File: rtl/qthresh_irq.sv
module qthresh_irq #(
  parameter int IBI_DEPTH  = 8,
  parameter int RESP_DEPTH = 4,
  parameter int CMD_DEPTH  = 8,
  localparam int IW = $clog2(IBI_DEPTH + 1),
  localparam int RW = $clog2(RESP_DEPTH + 1),
  localparam int CW = $clog2(CMD_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  output logic [31:0]   rd_data,
  input  logic [IW-1:0] ibi_count,
  input  logic [RW-1:0] resp_count,
  input  logic [CW-1:0] cmd_free,
  output logic          ibi_irq,
  output logic          resp_irq,
  output logic          cmd_irq,
  output logic [7:0]    seg_size
);

  localparam logic [31:0] RESET_WORD = 32'h0100_0100;
  localparam logic [7:0]  IBI_MAX    = 8'(IBI_DEPTH - 1);
  localparam logic [7:0]  RESP_MAX   = 8'(RESP_DEPTH - 1);
  localparam logic [7:0]  CMD_MAX    = 8'(CMD_DEPTH - 1);

  logic [31:0] ctrl_q;
  logic [7:0]  ibi_lim, resp_lim, cmd_lim;
  logic        ibi_hit, resp_hit, cmd_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     ctrl_q <= RESET_WORD;
    else if (wr_en) ctrl_q <= wr_data;

  assign rd_data  = ctrl_q;
  assign seg_size = ctrl_q[23:16];

  assign ibi_lim  = (ctrl_q[31:24] > IBI_MAX)  ? IBI_MAX  : ctrl_q[31:24];
  assign resp_lim = (ctrl_q[15:8]  > RESP_MAX) ? RESP_MAX : ctrl_q[15:8];
  assign cmd_lim  = (ctrl_q[7:0]   > CMD_MAX)  ? CMD_MAX  : ctrl_q[7:0];

  assign ibi_hit  = 9'(ibi_count)  >= ({1'b0, ibi_lim}  + 9'd1);
  assign resp_hit = 9'(resp_count) >= ({1'b0, resp_lim} + 9'd1);
  assign cmd_hit  = (ctrl_q[7:0] == 8'd0) ? (32'(cmd_free) == CMD_DEPTH)
                                          : (9'(cmd_free) >= {1'b0, cmd_lim});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ibi_irq  <= 1'b0;
      resp_irq <= 1'b0;
      cmd_irq  <= 1'b0;
    end else begin
      ibi_irq  <= ibi_hit;
      resp_irq <= resp_hit;
      cmd_irq  <= cmd_hit;
    end

  p_reset_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rd_data == RESET_WORD);
  p_write_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));
  p_ibi_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ibi_count == '0 |=> !ibi_irq);
  p_ibi_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ibi_count) == IBI_DEPTH |=> ibi_irq);
  p_resp_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_count == '0 |=> !resp_irq);
  p_resp_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(resp_count) == RESP_DEPTH |=> resp_irq);
  p_cmd_none_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_free == '0 |=> !cmd_irq);
  p_cmd_all_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cmd_free) == CMD_DEPTH |=> cmd_irq);
  p_flags_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(ibi_count) && $stable(ctrl_q[31:24])) |=> $stable(ibi_irq));
  p_seg_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seg_size == rd_data[23:16]);

endmodule

// File: tb/qthresh_irq_test.sv
`timescale 1ns/1ps
module qthresh_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  ibi_count = '0;
  logic [2:0]  resp_count = '0;
  logic [3:0]  cmd_free = '0;
  logic        ibi_irq, resp_irq, cmd_irq;
  logic [7:0]  seg_size;
  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  qthresh_irq uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] w);
    @(negedge clk) begin wr_en = 1'b1; wr_data = w; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic settle;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic exp_nplus1(input int fld, input int maxv, input int cnt);
    int t = (fld > maxv) ? maxv : fld;
    return cnt >= t + 1;
  endfunction

  function automatic logic exp_cmd(input int fld, input int cnt);
    if (fld == 0) return cnt == 8;
    return cnt >= ((fld > 7) ? 7 : fld);
  endfunction

  task automatic t_reset;
    chk("R1 word", rd_data, 32'h0100_0100);
    chk("R1 ibi", 32'(ibi_irq), 0);
    chk("R1 resp", 32'(resp_irq), 0);
    chk("R1 cmd", 32'(cmd_irq), 0);
    chk("R1 seg", 32'(seg_size), 0);
  endtask

  task automatic t_readback;
    write_word(32'hFF_1E_09_0A);
    chk("R2 readback", rd_data, 32'hFF1E090A);
    write_word(32'h05_01_02_03);
    chk("R2 readback", rd_data, 32'h05010203);
  endtask

  task automatic t_ibi;
    int fl[10] = '{0,1,2,3,4,5,6,7,9,255};
    foreach (fl[i]) begin
      write_word({fl[i][7:0], 8'd0, 8'd0, 8'd1});
      for (int c = 0; c <= 8; c++) begin
        ibi_count = 4'(c);
        settle();
        chk(fl[i] > 7 ? "R4 ibi clamp" : "R3 ibi", 32'(ibi_irq), 32'(exp_nplus1(fl[i], 7, c)));
      end
    end
  endtask

  task automatic t_resp;
    int fl[6] = '{0,1,2,3,4,200};
    foreach (fl[i]) begin
      write_word({8'd0, 8'd0, fl[i][7:0], 8'd1});
      for (int c = 0; c <= 4; c++) begin
        resp_count = 3'(c);
        settle();
        chk(fl[i] > 3 ? "R6 resp clamp" : "R5 resp", 32'(resp_irq), 32'(exp_nplus1(fl[i], 3, c)));
      end
    end
  endtask

  task automatic t_cmd;
    int fl[10] = '{0,1,2,3,4,5,6,7,8,255};
    foreach (fl[i]) begin
      write_word({8'd0, 8'd0, 8'd0, fl[i][7:0]});
      for (int c = 0; c <= 8; c++) begin
        cmd_free = 4'(c);
        settle();
        chk(fl[i] == 0 ? "R8 cmd empty" : (fl[i] > 7 ? "R9 cmd clamp" : "R7 cmd"),
            32'(cmd_irq), 32'(exp_cmd(fl[i], c)));
      end
    end
  endtask

  task automatic t_latency;
    write_word(32'h02_00_00_03);
    ibi_count = 4'd0;
    settle();
    chk("R10 idle", 32'(ibi_irq), 0);
    @(negedge clk) ibi_count = 4'd3;
    #1 chk("R10 not yet", 32'(ibi_irq), 0);
    @(posedge clk) #1 chk("R10 rise", 32'(ibi_irq), 1);
    @(negedge clk) ibi_count = 4'd2;
    #1 chk("R10 still high", 32'(ibi_irq), 1);
    @(posedge clk) #1 chk("R10 fall", 32'(ibi_irq), 0);
    @(negedge clk) begin wr_en = 1'b1; wr_data = 32'h01_00_00_03; end
    @(posedge clk) #1 begin
      wr_en = 1'b0;
      chk("R10 thr written", 32'(ibi_irq), 0);
    end
    @(posedge clk) #1 chk("R10 thr rise", 32'(ibi_irq), 1);
  endtask

  task automatic t_seg;
    ibi_count = 4'd1; resp_count = 3'd1; cmd_free = 4'd3;
    write_word(32'h00_00_00_03);
    settle();
    chk("R11 base ibi", 32'(ibi_irq), 1);
    write_word(32'h00_1F_00_03);
    settle();
    chk("R11 seg", 32'(seg_size), 32'h1F);
    chk("R11 ibi", 32'(ibi_irq), 1);
    chk("R11 resp", 32'(resp_irq), 1);
    chk("R11 cmd", 32'(cmd_irq), 1);
  endtask

  initial begin
    #(5 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_readback();
    t_ibi();
    t_resp();
    t_cmd();
    t_latency();
    t_seg();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule